// File: doc/BRIEF.md
# Progressive Video Line Timer

This block produces the horizontal timing of one progressive video line and picks the word that leaves the block on each pixel clock. A frame position counter runs over the whole 1650-sample line and wraps. A second counter, the image index, counts pixels inside a programmable image window placed in the 1280-sample active area. The window normally sits at offset 8 with a width of 1264, which centres it.

Each line carries an end-of-active-video code, then blanking data, then a start-of-active-video code, then the active area. In the active area, the output is image pixels taken from an external FIFO inside the window, and fill data around the window. Active-low blanking and sync strobes go with the data. Every output lags the counters by exactly two pixel clocks. The FIFO read strobe is issued two clocks ahead of the slot it feeds, and the FIFO is assumed to return data one clock after the read.

Output words are 20 bits wide: luma in bits 19:10 and chroma in bits 9:0. Timing codes are placed on both halves.

Top module: `vid_line_timer`

## Requirements
- R1: The frame position counter counts 0 to 1649 and wraps to 0. The blanking strobe therefore falls exactly once every 1650 clocks.
- R2: Outputs lag the frame position by exactly two clocks. The output for sample n appears in the clock where the counter holds n+2.
- R3: With `cfg_blank_late` clear, `hblank_n` is low for samples 1280 through 1645 and high elsewhere. It releases on the first start-code word.
- R4: With `cfg_blank_late` set, `hblank_n` is low for samples 1280 through 1649 and releases at sample 0, after the start code.
- R5: `hsync_n` is low for samples 1280 up to, but not including, `cfg_sync_stop`, and high elsewhere.
- R6: Samples 1280 to 1283 carry the end code. The four words are 3FF, 000, 000 and 274, where 274 is the status word with the blanking bit (bit 6) set and its protection bits 5, 4 and 2 set. Each word is on both halves.
- R7: Samples 1646 to 1649 carry the start code. The four words are 3FF, 000, 000 and 200, where 200 is the status word with the blanking bit clear. Each word is on both halves.
- R8: Samples 1284 to 1645 carry the blanking level, which is luma 040 and chroma 200.
- R9: Active samples outside the image window output `cfg_fill` when `cfg_fill_en` is set, and the blanking level when it is clear.
- R10: `fifo_rd` is high in exactly the clocks whose sample lies in the window (from `cfg_win_start` for `cfg_win_len` samples), once per image pixel and never outside the active area.
- R11: Each window sample outputs, in order, the FIFO word returned for the matching read.
- R12: While `rst` is held, `hblank_n` and `hsync_n` are high, `vout` is the blanking level, and the counters sit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_start | input | 11 | First sample of the image window |
| cfg_win_len | input | 11 | Image window width in samples (at least 1) |
| cfg_sync_stop | input | 11 | First sample after the sync pulse |
| cfg_blank_late | input | 1 | Release blanking after the start code instead of on it |
| cfg_fill_en | input | 1 | Enable fill data around the window |
| cfg_fill | input | 20 | Fill word, luma in 19:10 and chroma in 9:0 |
| fifo_data | input | 20 | FIFO word, valid one clock after `fifo_rd` |
| fifo_rd | output | 1 | FIFO read strobe |
| vout | output | 20 | Output data word |
| hblank_n | output | 1 | Active-low horizontal blanking |
| hsync_n | output | 1 | Active-low horizontal sync |

## Verification
The line is run with four configurations, each over two full lines and compared every clock against a behavioural model. The centred 8/1264 window with fill enabled separates fill words from FIFO words at both window edges. The same window with the late-release bit set and fill disabled separates the two blanking release points and the two kinds of non-image output. A full-width window starting at 0 exercises the read strobe across the line wrap. A one-pixel window with a one-sample sync pulse checks that the image counter stops after a single read and that the sync stop compare works at its smallest setting.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

    localparam int CW       = 10;
    localparam int PW       = 2 * CW;
    localparam int CODE_LEN = 4;

    localparam logic [CW-1:0] BLK_Y = 10'h040;
    localparam logic [CW-1:0] BLK_C = 10'h200;

    typedef enum logic [2:0] {
        SRC_EAV,
        SRC_BLANK,
        SRC_SAV,
        SRC_FILL,
        SRC_FIFO
    } src_e;

    typedef struct packed {
        src_e       src;
        logic [1:0] idx;
        logic       blank;
        logic       sync;
    } slot_t;

    localparam slot_t SLOT_IDLE = '{src: SRC_BLANK, idx: 2'd0, blank: 1'b0, sync: 1'b0};

    // status word for a progressive line: field and vertical bits are zero
    function automatic logic [CW-1:0] status_word(input logic h);
        return {1'b1, 2'b00, h, h, h, 1'b0, h, 2'b00};
    endfunction

    function automatic logic [CW-1:0] code_word(input logic [1:0] idx, input logic h);
        case (idx)
            2'd0:    return '1;
            2'd3:    return status_word(h);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/vlt_line_counter.sv
module vlt_line_counter #(
    parameter int LINE_LEN = 1650,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_win_start,
    input  logic [CNT_W-1:0] cfg_win_len,
    output logic [CNT_W-1:0] fp,
    output logic [CNT_W-1:0] ip,
    output logic             run
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_LEN - 1);

    logic [CNT_W-1:0] fp_nxt;
    logic [CNT_W-1:0] len_last;
    logic             win_ok;

    assign fp_nxt   = (fp == LAST) ? '0 : fp + 1'b1;
    assign len_last = cfg_win_len - 1'b1;
    assign win_ok   = (cfg_win_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fp  <= '0;
            ip  <= '0;
            run <= (cfg_win_start == '0) && win_ok;
        end else begin
            fp <= fp_nxt;
            if ((fp_nxt == cfg_win_start) && win_ok) begin
                run <= 1'b1;
                ip  <= '0;
            end else if (run) begin
                if (ip == len_last) run <= 1'b0;
                else                ip  <= ip + 1'b1;
            end
        end
    end

    // R1
    fp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fp == LAST) |=> (fp == '0));

    // R1
    fp_range_chk: assert property (@(posedge clk) disable iff (rst)
        fp <= LAST);

    // R10
    ip_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (ip < cfg_win_len));

endmodule

// File: rtl/vlt_slot_decode.sv
module vlt_slot_decode
    import vlt_pkg::*;
#(
    parameter int LINE_LEN = 1650,
    parameter int ACT_LEN  = 1280,
    parameter int CNT_W    = 11
) (
    input  logic [CNT_W-1:0] fp,
    input  logic             run,
    input  logic             cfg_blank_late,
    input  logic             cfg_fill_en,
    input  logic [CNT_W-1:0] cfg_sync_stop,
    output slot_t            slot,
    output logic             fifo_rd
);

    localparam logic [CNT_W-1:0] EAV_FIRST = CNT_W'(ACT_LEN);
    localparam logic [CNT_W-1:0] EAV_LAST  = CNT_W'(ACT_LEN + CODE_LEN - 1);
    localparam logic [CNT_W-1:0] SAV_FIRST = CNT_W'(LINE_LEN - CODE_LEN);

    logic [CNT_W-1:0] eav_off;
    logic [CNT_W-1:0] sav_off;
    logic             in_act;

    assign eav_off = fp - EAV_FIRST;
    assign sav_off = fp - SAV_FIRST;
    assign in_act  = (fp < EAV_FIRST);

    always_comb begin
        slot    = SLOT_IDLE;
        fifo_rd = 1'b0;
        if (in_act) begin
            if (run) begin
                slot.src = SRC_FIFO;
                fifo_rd  = 1'b1;
            end else if (cfg_fill_en) begin
                slot.src = SRC_FILL;
            end
        end else if (fp <= EAV_LAST) begin
            slot.src = SRC_EAV;
            slot.idx = eav_off[1:0];
        end else if (fp >= SAV_FIRST) begin
            slot.src = SRC_SAV;
            slot.idx = sav_off[1:0];
        end
        slot.blank = !in_act && ((fp < SAV_FIRST) || cfg_blank_late);
        slot.sync  = !in_act && (fp < cfg_sync_stop);
    end

endmodule

// File: rtl/vlt_out_pipe.sv
module vlt_out_pipe
    import vlt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  slot_t         slot_in,
    input  logic [PW-1:0] cfg_fill,
    input  logic [PW-1:0] fifo_data,
    output logic [PW-1:0] vout,
    output logic          hblank_n,
    output logic          hsync_n
);

    slot_t         s1;
    logic [PW-1:0] word;
    logic [CW-1:0] code;

    always_ff @(posedge clk) begin
        if (rst) s1 <= SLOT_IDLE;
        else     s1 <= slot_in;
    end

    always_comb begin
        code = code_word(s1.idx, s1.src == SRC_EAV);
        case (s1.src)
            SRC_EAV, SRC_SAV: word = {code, code};
            SRC_FILL:         word = cfg_fill;
            SRC_FIFO:         word = fifo_data;
            default:          word = {BLK_Y, BLK_C};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vout     <= {BLK_Y, BLK_C};
            hblank_n <= 1'b1;
            hsync_n  <= 1'b1;
        end else begin
            vout     <= word;
            hblank_n <= ~s1.blank;
            hsync_n  <= ~s1.sync;
        end
    end

    // R11
    fifo_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (s1.src == SRC_FIFO) |=> (vout == $past(fifo_data)));

    // R8
    blank_level_chk: assert property (@(posedge clk) disable iff (rst)
        (s1.src == SRC_BLANK) |=> (vout == {BLK_Y, BLK_C}));

endmodule

// File: rtl/vid_line_timer.sv
module vid_line_timer
    import vlt_pkg::*;
#(
    parameter int   LINE_LEN = 1650,
    parameter int   ACT_LEN  = 1280,
    localparam int  CNT_W    = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_win_start,
    input  logic [CNT_W-1:0] cfg_win_len,
    input  logic [CNT_W-1:0] cfg_sync_stop,
    input  logic             cfg_blank_late,
    input  logic             cfg_fill_en,
    input  logic [PW-1:0]    cfg_fill,
    input  logic [PW-1:0]    fifo_data,
    output logic             fifo_rd,
    output logic [PW-1:0]    vout,
    output logic             hblank_n,
    output logic             hsync_n
);

    logic [CNT_W-1:0] fp;
    logic [CNT_W-1:0] ip;
    logic             run;
    slot_t            slot;

    vlt_line_counter #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .cfg_win_start (cfg_win_start),
        .cfg_win_len   (cfg_win_len),
        .fp            (fp),
        .ip            (ip),
        .run           (run)
    );

    vlt_slot_decode #(.LINE_LEN(LINE_LEN), .ACT_LEN(ACT_LEN), .CNT_W(CNT_W)) u_dec (
        .fp             (fp),
        .run            (run),
        .cfg_blank_late (cfg_blank_late),
        .cfg_fill_en    (cfg_fill_en),
        .cfg_sync_stop  (cfg_sync_stop),
        .slot           (slot),
        .fifo_rd        (fifo_rd)
    );

    vlt_out_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .slot_in   (slot),
        .cfg_fill  (cfg_fill),
        .fifo_data (fifo_data),
        .vout      (vout),
        .hblank_n  (hblank_n),
        .hsync_n   (hsync_n)
    );

    // R10
    rd_active_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (fp < CNT_W'(ACT_LEN)));

    // R6
    eav_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (fp == CNT_W'(ACT_LEN + 2)) |-> (vout == '1));

    // R3
    blank_release_chk: assert property (@(posedge clk) disable iff (rst)
        (fp == CNT_W'(LINE_LEN - CODE_LEN + 2)) |-> (hblank_n == !cfg_blank_late));

    // R4
    blank_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fp == CNT_W'(2)) |-> hblank_n);

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (hblank_n && hsync_n));

endmodule

// File: tb/sim_vid_line_timer.sv
module sim_vid_line_timer;

    localparam int LINE = 1650;
    localparam int ACT  = 1280;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] cfg_win_start = '0;
    logic [10:0] cfg_win_len = 11'd1;
    logic [10:0] cfg_sync_stop = 11'd1300;
    logic        cfg_blank_late = 1'b0;
    logic        cfg_fill_en = 1'b0;
    logic [19:0] cfg_fill = '0;
    logic [19:0] fifo_data;
    logic        fifo_rd;
    logic [19:0] vout;
    logic        hblank_n;
    logic        hsync_n;

    int n_chk  = 0;
    int n_fail = 0;
    int rdcnt;
    bit done = 0;

    typedef struct {
        logic [19:0] v;
        logic        hb;
        logic        hs;
        string       vtag;
        string       hbtag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    vid_line_timer u0 (
        .clk            (clk),
        .rst            (rst),
        .cfg_win_start  (cfg_win_start),
        .cfg_win_len    (cfg_win_len),
        .cfg_sync_stop  (cfg_sync_stop),
        .cfg_blank_late (cfg_blank_late),
        .cfg_fill_en    (cfg_fill_en),
        .cfg_fill       (cfg_fill),
        .fifo_data      (fifo_data),
        .fifo_rd        (fifo_rd),
        .vout           (vout),
        .hblank_n       (hblank_n),
        .hsync_n        (hsync_n)
    );

    function automatic logic [19:0] pattern(input int n);
        return {n[9:0] ^ 10'h155, n[9:0]};
    endfunction

    // bench FIFO: one clock read latency
    always @(posedge clk) begin
        if (rst) begin
            rdcnt     <= 0;
            fifo_data <= '0;
        end else if (fifo_rd) begin
            fifo_data <= pattern(rdcnt);
            rdcnt     <= rdcnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic run_cfg(input int ws, input int wl, input int stop, input bit late,
                           input bit fen, input logic [19:0] fill);
        int mfp = 0;
        int nread = 0;
        int last_fall = -1;
        logic prev_hb = 1'b1;
        q.delete();
        @(negedge clk);
        rst = 1'b1;
        cfg_win_start  = 11'(ws);
        cfg_win_len    = 11'(wl);
        cfg_sync_stop  = 11'(stop);
        cfg_blank_late = late;
        cfg_fill_en    = fen;
        cfg_fill       = fill;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) q.push_back('{v: 20'h10200, hb: 1'b1, hs: 1'b1,
                                                   vtag: "R12", hbtag: "R12"});
        rst = 1'b0;
        for (int c = 0; c < 2 * LINE + 10; c++) begin
            exp_t e;
            exp_t o;
            bit   win;
            if (c > 0) @(negedge clk);
            win = (mfp >= ws) && (mfp < ws + wl) && (mfp < ACT);
            // R10 read strobe exactly on window samples
            chk("R10", {19'd0, fifo_rd}, {19'd0, win});
            e.hb    = !((mfp >= ACT) && ((mfp < LINE - 4) || late));
            e.hs    = !((mfp >= ACT) && (mfp < stop));
            e.hbtag = late ? "R4" : "R3";
            if (mfp < ACT) begin
                if (win) begin
                    e.v = pattern(nread); nread++; e.vtag = "R11";
                end else begin
                    e.v = fen ? fill : 20'h10200; e.vtag = "R9";
                end
            end else if (mfp < ACT + 4) begin
                case (mfp - ACT)
                    0: e.v = 20'hFFFFF;
                    3: e.v = {10'h274, 10'h274};
                    default: e.v = 20'h0;
                endcase
                e.vtag = "R6";
            end else if (mfp >= LINE - 4) begin
                case (mfp - (LINE - 4))
                    0: e.v = 20'hFFFFF;
                    3: e.v = {10'h200, 10'h200};
                    default: e.v = 20'h0;
                endcase
                e.vtag = "R7";
            end else begin
                e.v = 20'h10200; e.vtag = "R8";
            end
            q.push_back(e);
            o = q.pop_front();
            chk(o.vtag, vout, o.v);
            chk(o.hbtag, {19'd0, hblank_n}, {19'd0, o.hb});
            chk((o.vtag == "R12") ? "R12" : "R5", {19'd0, hsync_n}, {19'd0, o.hs});
            // R2: two-clock lag seen at the end-code boundary
            if (c == ACT + 1) chk("R2", {19'd0, hblank_n}, 20'd1);
            if (c == ACT + 2) begin
                chk("R2", {19'd0, hblank_n}, 20'd0);
                chk("R2", vout, 20'hFFFFF);
            end
            // R1: blanking falls once per 1650 clocks
            if (prev_hb && !hblank_n) begin
                if (last_fall >= 0) chk("R1", 20'(c - last_fall), 20'(LINE));
                last_fall = c;
            end
            prev_hb = hblank_n;
            mfp = (mfp + 1) % LINE;
        end
    endtask

    initial begin
        run_cfg(8,   1264, 1320, 1'b0, 1'b1, 20'h12345);
        run_cfg(8,   1264, 1400, 1'b1, 1'b0, 20'h12345);
        run_cfg(0,   1280, 1645, 1'b0, 1'b1, 20'h0ABCD);
        run_cfg(500, 1,    1281, 1'b1, 1'b1, 20'h3C00F);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule